// File: doc/BRIEF.md
# Power Stage Protection Controller

This block supervises a switching power output stage. Analog monitors report three asynchronous flags and a digitized junction temperature code: overcurrent, undervoltage on the gate-drive supply and undervoltage on the regulator supply. The block drives three outputs. The first is an enable that keeps the output stage driving, or places it in high impedance when low. The second is an active-low fault flag. The third is an active-high temperature warning flag.

Shutdown faults remove the enable and pull the fault flag low. An undervoltage shutdown ends as soon as both supplies are healthy again. An overcurrent trip, or a temperature at or above the trip code, is held until a system controller pulses the active-low control reset. While that reset is low, the fault flag reads inactive whatever is present, and the stage is kept in high impedance.

The block carries no data stream. Every pin is a plain level control or status signal, so no valid/ready handshake and no back-pressure apply. Each asynchronous input, the control reset included, passes through a two-flop synchronizer. For this reason every output reacts on the third rising clock edge after its input changes.

Top module: `ppc_protect_top`

## Requirements
- R1: With the control reset high, no flag set and the temperature code at or below WARN_CODE (default 125), the outputs settle to stage_en=1, fault_n=1 and hot_warn=0.
- R2: If oc_flag, uv_gate_flag or uv_reg_flag is 1, or temp_code is at or above TRIP_CODE (default 150), while the synchronized control reset is high, then stage_en=0 and fault_n=0 from the third rising edge after the input changes. stage_en is never 1 while fault_n is 0.
- R3: hot_warn is 1 exactly when temp_code is above WARN_CODE, with three edges of latency, whatever the reset and fault state. A warning alone leaves stage_en=1 and fault_n=1.
- R4: An undervoltage shutdown clears by itself. Once both undervoltage flags are 0 and no other cause is present, fault_n returns to 1 on the third edge.
- R5: An overcurrent trip stays latched after oc_flag returns to 0, and fault_n stays 0 until the control reset is pulsed.
- R6: An over-temperature trip stays latched after temp_code drops below TRIP_CODE, until the control reset is pulsed.
- R7: A latched trip clears only if its cause is absent when the control reset returns high. If the cause is still present, the fault stays asserted after release.
- R8: While the synchronized control reset is low, fault_n=1 and stage_en=0, whatever faults are present.
- R9: stage_en rises no earlier than one clock after fault_n reads 1. After a fault clears, fault_n rises on the third edge and stage_en on the fourth.
- R10: While por_n is low, stage_en=0, fault_n=1 and hot_warn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of all flops |
| stage_rst_n | input | 1 | Active-low control reset from the system controller (asynchronous) |
| oc_flag | input | 1 | Overcurrent monitor flag, 1 = overcurrent (asynchronous) |
| uv_gate_flag | input | 1 | Gate-drive supply undervoltage flag, 1 = low (asynchronous) |
| uv_reg_flag | input | 1 | Regulator supply undervoltage flag, 1 = low (asynchronous) |
| temp_code | input | TEMP_W | Junction temperature code, held stable between updates |
| stage_en | output | 1 | 1 = output stage drives, 0 = high impedance |
| fault_n | output | 1 | Active-low shutdown fault flag |
| hot_warn | output | 1 | Active-high temperature warning flag |

## Verification
The delicate collision is the release of the control reset in the same cycle that a new overcurrent arrives. The latch must capture the cause in the same cycle that the mask on fault_n lifts. The bench provokes this by raising stage_rst_n and oc_flag at the same clock edge. It then expects fault_n=0 three edges later and stage_en to stay 0 with no one-cycle pulse. Randomized runs also mix reset pulses with fault edges, and a cycle-level bench model judges each cycle.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  // Sources that hold their shutdown until a control reset pulse.
  typedef enum int unsigned {
    SRC_OVERCURRENT = 0,
    SRC_OVERTEMP    = 1
  } latch_src_e;

  localparam int unsigned LATCH_CNT = 2;

  // Single-bit asynchronous monitor flags, synchronized together.
  typedef struct packed {
    logic oc;
    logic uv_gate;
    logic uv_reg;
    logic ctl_rst_n;
  } mon_flags_t;

  localparam int unsigned FLAG_W = $bits(mon_flags_t);

endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ppc_temp_judge.sv
module ppc_temp_judge #(
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned WARN_CODE = 125,
  parameter int unsigned TRIP_CODE = 150
) (
  input  logic [TEMP_W-1:0] temp,
  output logic              hot,
  output logic              trip
);

  localparam logic [TEMP_W-1:0] WARN_V = WARN_CODE[TEMP_W-1:0];
  localparam logic [TEMP_W-1:0] TRIP_V = TRIP_CODE[TEMP_W-1:0];

  // The warning means strictly above its code. The trip includes its code.
  always_comb begin
    hot  = (temp > WARN_V);
    trip = (temp >= TRIP_V);
  end

endmodule

// File: rtl/ppc_fault_latch.sv
module ppc_fault_latch (
  input  logic clk,
  input  logic por_n,
  input  logic armed,
  input  logic cause,
  output logic held
);

  // While disarmed (control reset low), the latch follows its cause. On
  // release it therefore keeps only a cause that is still present.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     held <= 1'b0;
    else if (armed) held <= held | cause;
    else            held <= cause;
  end

endmodule

// File: rtl/ppc_out_ctrl.sv
module ppc_out_ctrl (
  input  logic clk,
  input  logic por_n,
  input  logic ctl_ok,
  input  logic fault_any,
  input  logic hot,
  output logic stage_en,
  output logic fault_n,
  output logic hot_warn
);

  logic clean_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      clean_q  <= 1'b0;
      stage_en <= 1'b0;
      fault_n  <= 1'b1;
      hot_warn <= 1'b0;
    end else begin
      clean_q  <= ctl_ok & ~fault_any;
      // Shutdown takes effect at once. Enable needs one clean cycle first.
      stage_en <= ctl_ok & ~fault_any & clean_q;
      fault_n  <= ~ctl_ok | ~fault_any;
      hot_warn <= hot;
    end
  end

endmodule

// File: rtl/ppc_protect_top.sv
module ppc_protect_top #(
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned WARN_CODE   = 125,
  parameter int unsigned TRIP_CODE   = 150,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              stage_rst_n,
  input  logic              oc_flag,
  input  logic              uv_gate_flag,
  input  logic              uv_reg_flag,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              stage_en,
  output logic              fault_n,
  output logic              hot_warn
);
  import ppc_pkg::*;

  mon_flags_t        raw_flags;
  mon_flags_t        s_flags;
  logic [TEMP_W-1:0] s_temp;

  logic s_rstn, s_oc, s_uv, s_hot, s_trip;
  logic [LATCH_CNT-1:0] cause;
  logic [LATCH_CNT-1:0] held;
  logic fault_any;

  always_comb begin
    raw_flags.oc        = oc_flag;
    raw_flags.uv_gate   = uv_gate_flag;
    raw_flags.uv_reg    = uv_reg_flag;
    raw_flags.ctl_rst_n = stage_rst_n;
  end

  ppc_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync_flags (
    .clk(clk), .por_n(por_n), .d(raw_flags), .q(s_flags)
  );

  ppc_sync #(.W(TEMP_W), .STAGES(SYNC_STAGES)) u_sync_temp (
    .clk(clk), .por_n(por_n), .d(temp_code), .q(s_temp)
  );

  ppc_temp_judge #(.TEMP_W(TEMP_W), .WARN_CODE(WARN_CODE), .TRIP_CODE(TRIP_CODE)) u_judge (
    .temp(s_temp), .hot(s_hot), .trip(s_trip)
  );

  assign s_rstn = s_flags.ctl_rst_n;
  assign s_oc   = s_flags.oc;
  assign s_uv   = s_flags.uv_gate | s_flags.uv_reg;

  always_comb begin
    cause                  = '0;
    cause[SRC_OVERCURRENT] = s_oc;
    cause[SRC_OVERTEMP]    = s_trip;
  end

  generate
    for (genvar i = 0; i < LATCH_CNT; i++) begin : g_latch
      ppc_fault_latch u_latch (
        .clk(clk), .por_n(por_n), .armed(s_rstn), .cause(cause[i]), .held(held[i])
      );
    end
  endgenerate

  // Live causes give immediate shutdown. Held causes keep it.
  assign fault_any = s_uv | (|cause) | (|held);

  ppc_out_ctrl u_out (
    .clk(clk), .por_n(por_n), .ctl_ok(s_rstn), .fault_any(fault_any), .hot(s_hot),
    .stage_en(stage_en), .fault_n(fault_n), .hot_warn(hot_warn)
  );

endmodule

// File: rtl/ppc_protect_chk.sv
module ppc_protect_chk (
  input logic       clk,
  input logic       por_n,
  input logic       s_rstn,
  input logic       s_oc,
  input logic       s_uv,
  input logic       s_hot,
  input logic       s_trip,
  input logic [1:0] held,
  input logic       stage_en,
  input logic       fault_n,
  input logic       hot_warn
);

  assert_reset_masks_R8: assert property (@(posedge clk) disable iff (!por_n)
    !s_rstn |=> (fault_n && !stage_en));

  assert_shutdown_R2: assert property (@(posedge clk) disable iff (!por_n)
    (s_rstn && (s_oc || s_uv || s_trip)) |=> (!fault_n && !stage_en));

  assert_fault_gates_en_R2: assert property (@(posedge clk) disable iff (!por_n)
    !fault_n |-> !stage_en);

  assert_warn_on_R3: assert property (@(posedge clk) disable iff (!por_n)
    s_hot |=> hot_warn);

  assert_warn_off_R3: assert property (@(posedge clk) disable iff (!por_n)
    !s_hot |=> !hot_warn);

  assert_self_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
    (s_rstn && !s_oc && !s_uv && !s_trip && (held == 2'b00)) |=> fault_n);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    (s_rstn && (held != 2'b00) && !fault_n) |=> !fault_n);

  assert_en_gap_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stage_en) |-> $past(fault_n));

  always @(negedge clk) begin
    if (!por_n) begin
      assert_por_state_R10: assert (!stage_en && fault_n && !hot_warn);
    end
  end

endmodule

bind ppc_protect_top ppc_protect_chk u_chk (
  .clk(clk), .por_n(por_n), .s_rstn(s_rstn), .s_oc(s_oc), .s_uv(s_uv),
  .s_hot(s_hot), .s_trip(s_trip), .held(held), .stage_en(stage_en),
  .fault_n(fault_n), .hot_warn(hot_warn)
);

// File: tb/test_ppc_protect_top.sv
module test_ppc_protect_top;

  localparam int unsigned TW   = 8;
  localparam int unsigned WARN = 125;
  localparam int unsigned TRIP = 150;

  logic clk = 1'b0;
  logic por_n, rst_req_n, oc, uvg, uvr;
  logic [TW-1:0] temp;
  logic stage_en, fault_n, hot_warn;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  ppc_protect_top #(.TEMP_W(TW), .WARN_CODE(WARN), .TRIP_CODE(TRIP)) i_ppc_protect_top (
    .clk(clk), .por_n(por_n), .stage_rst_n(rst_req_n), .oc_flag(oc),
    .uv_gate_flag(uvg), .uv_reg_flag(uvr), .temp_code(temp),
    .stage_en(stage_en), .fault_n(fault_n), .hot_warn(hot_warn)
  );

  // Cycle model built from the requirements: two sync edges, then outputs.
  logic [3:0] m_s1, m_s2;
  logic [TW-1:0] m_t1, m_t2;
  logic m_oc_h, m_ote_h, m_fn, m_en, m_clean, m_w;

  function automatic logic exp_cause(input logic [3:0] f, input logic [TW-1:0] t,
                                     input logic oh, input logic th);
    return f[3] | f[2] | f[1] | (t >= TW'(TRIP)) | oh | th;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 <= '0; m_s2 <= '0; m_t1 <= '0; m_t2 <= '0;
      m_oc_h <= 0; m_ote_h <= 0; m_fn <= 1; m_en <= 0; m_clean <= 0; m_w <= 0;
    end else begin
      m_oc_h  <= m_s2[0] ? (m_oc_h | m_s2[3]) : m_s2[3];
      m_ote_h <= m_s2[0] ? (m_ote_h | (m_t2 >= TW'(TRIP))) : (m_t2 >= TW'(TRIP));
      m_fn    <= !m_s2[0] | !exp_cause(m_s2, m_t2, m_oc_h, m_ote_h);
      m_clean <= m_s2[0] & !exp_cause(m_s2, m_t2, m_oc_h, m_ote_h);
      m_en    <= m_s2[0] & !exp_cause(m_s2, m_t2, m_oc_h, m_ote_h) & m_clean;
      m_w     <= (m_t2 > TW'(WARN));
      m_s2 <= m_s1; m_t2 <= m_t1;
      m_s1 <= {oc, uvg, uvr, rst_req_n}; m_t1 <= temp;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tag, input logic e_en, input logic e_fn, input logic e_w);
    check({tag, " stage_en"}, stage_en, e_en);
    check({tag, " fault_n"},  fault_n,  e_fn);
    check({tag, " hot_warn"}, hot_warn, e_w);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reset();
    rst_req_n = 1'b0; wait_n(6);
    rst_req_n = 1'b1; wait_n(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    por_n = 0; rst_req_n = 1; oc = 0; uvg = 0; uvr = 0; temp = 8'd25;
    wait_n(3);
    outs("R10 por", 0, 1, 0);
    por_n = 1;
    wait_n(6);
    outs("R1 idle", 1, 1, 0);

    // R3: warning edges around the warning code
    temp = 8'd126; wait_n(3);
    outs("R3 warn on", 1, 1, 1);
    temp = 8'd125; wait_n(3);
    outs("R3 warn off", 1, 1, 0);

    // R2 and R5: overcurrent trips and stays latched
    oc = 1; wait_n(3);
    outs("R2 oc trip", 0, 0, 0);
    oc = 0; wait_n(10);
    outs("R5 oc held", 0, 0, 0);

    // R7 and R8: reset with cause still present
    oc = 1; rst_req_n = 0; wait_n(6);
    outs("R8 masked", 0, 1, 0);
    rst_req_n = 1; wait_n(6);
    outs("R7 still tripped", 0, 0, 0);
    oc = 0; wait_n(6);
    outs("R7 cause gone, no pulse", 0, 0, 0);
    pulse_reset();
    outs("R7 cleared", 1, 1, 0);

    // R4 and R9: undervoltage recovers by itself, enable lags fault_n
    uvg = 1; wait_n(3);
    outs("R2 uv gate", 0, 0, 0);
    uvr = 1; uvg = 0; wait_n(5);
    outs("R4 uv reg still low", 0, 0, 0);
    uvr = 0; wait_n(3);
    outs("R9 fault_n first", 0, 1, 0);
    wait_n(1);
    outs("R4 recovered", 1, 1, 0);

    // R6: over-temperature trip latches
    temp = 8'd160; wait_n(3);
    outs("R6 trip", 0, 0, 1);
    temp = 8'd100; wait_n(6);
    outs("R6 held", 0, 0, 0);
    pulse_reset();
    outs("R6 cleared", 1, 1, 0);

    // R8: undervoltage during reset is masked on fault_n
    uvg = 1; rst_req_n = 0; wait_n(6);
    outs("R8 uv masked", 0, 1, 0);
    uvg = 0; rst_req_n = 1; wait_n(6);
    outs("R1 after release", 1, 1, 0);

    // Collision: reset release and new overcurrent on the same edge
    rst_req_n = 0; wait_n(6);
    rst_req_n = 1; oc = 1;
    for (int i = 0; i < 8; i++) begin
      wait_n(1);
      check("R2 collision stage_en", stage_en, 1'b0);
    end
    check("R5 collision fault_n", fault_n, 1'b0);
    oc = 0; pulse_reset();
    outs("R7 collision cleared", 1, 1, 0);

    // Random phase checked against the cycle model every cycle
    model_on = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      check("R2 model stage_en", stage_en, m_en);
      check("R8 model fault_n",  fault_n,  m_fn);
      check("R3 model hot_warn", hot_warn, m_w);
      if (($urandom % 60) == 0) oc = ~oc;
      if (($urandom % 25) == 0) uvg = ~uvg;
      if (($urandom % 25) == 0) uvr = ~uvr;
      if (($urandom % 40) == 0) rst_req_n = ~rst_req_n;
      if (($urandom % 30) == 0) temp = TW'(90 + ($urandom % 80));
    end
    finish_run();
  end

endmodule